// File: doc/BRIEF.md
# Grouped Digital Port with Edge-Triggered Status

This block is an eight-pin digital port. Its pins fall into two banks of four: the low bank covers pins 0 to 3 and the high bank covers pins 4 to 7. One configuration bit per bank turns all four pins of that bank into outputs. The same 16-bit configuration word also holds the output data, a sense-inversion option for the high bank, and one edge-select bit for each low-bank pin. Reading the configuration word returns the present level of every pin in its low byte.

Each low-bank pin passes through a two-flop synchronizer into a small edge tracker. The tracker is a state machine with three states. ED_WAIT holds the pin's first trusted level as a baseline after reset and reports no edge. ED_LOW and ED_HIGH hold the last seen level. The transitions are: ED_WAIT to ED_LOW or ED_HIGH (baseline taken once the synchronizer is full), ED_LOW to ED_HIGH (rise), and ED_HIGH to ED_LOW (fall). When a pin sees its selected edge, a status bit is set in a shared sticky register. Software clears that bit by writing a one to it. A mask register chooses which status bits drive the interrupt line. Status bits 8 to 11 belong to pins 0 to 3. The other bit positions are kept free for other sources.

Top module: `dio_grouped_port`

## Requirements
- R1: After reset the configuration word, mask and status are all zero, so `pin_oe` is 0x00, `pin_out` is 0x00 and `irq` is low.
- R2: With `reg_sel`=0 a write stores the configuration word. Bit 10 drives `pin_oe[3:0]` to all ones and bit 11 drives `pin_oe[7:4]` to all ones. Bits 7:0 are the output data on `pin_out`. A bank's four enables always match.
- R3: A read with `reg_sel`=0 returns pin levels in bits 7:0 and the stored bits 15:10 and 8 in place. For a pin in an input bank, the level is the external level, seen two clock edges after it changes. For a pin in an output bank, the level is its own data bit.
- R4: Configuration bit 8 inverts the high bank in both directions. `pin_out[7:4]` carries the data bits XOR 1, and an input-bank high pin reads back as the inverse of its pad. An output-bank high pin still reads back its data bit.
- R5: Configuration bits 12 to 15 select the edge for pins 0 to 3 (0 = rising, 1 = falling). The selected edge sets status bit 8+i, readable after the third clock edge following the pin change. The opposite edge sets nothing.
- R6: A status bit sets even when its mask bit is clear. `irq` is the OR over bits 11:8 of status AND mask, where the mask is written and read with `reg_sel`=1.
- R7: Writing with `reg_sel`=2 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a clearing write and a new edge on the same bit meet in one clock cycle, the bit stays set.
- R9: A low-bank pin held high through reset sets no status bit once reset is released. Its first synchronized level becomes the baseline.
- R10: Mask and status bits outside 11:8 read as 0 and ignore writes. Configuration bit 9 reads as 0. `reg_sel`=3 reads 0 and ignores writes. Pins 4 to 7 never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | 0 configuration, 1 mask, 2 status, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| pin_in | input | 8 | Pad levels, asynchronous |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The assertions assume that `reg_sel` and `reg_wdata` are defined whenever `reg_wr` is high. They also assume that a pin change lasts at least two clock cycles, so the synchronizer cannot swallow a pulse. The stimulus changes inputs only on falling clock edges. It holds each pin level for several cycles before it samples status. It lines up clearing writes with the exact cycle of an edge only in the collision case.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int PIN_COUNT    = 8;
    localparam int GROUP_SIZE   = 4;
    localparam int GROUP_COUNT  = PIN_COUNT / GROUP_SIZE;
    localparam int EDGE_PINS    = 4;
    localparam int REG_W        = 16;
    localparam int SYNC_STAGES  = 2;
    localparam int DIR_LSB      = 10;
    localparam int POL_BIT      = 8;
    localparam int POL_GROUP    = 1;
    localparam int EDGE_SEL_LSB = 12;
    localparam int IRQ_LSB      = 8;

    typedef enum logic [1:0] {
        ED_WAIT = 2'd0,
        ED_LOW  = 2'd1,
        ED_HIGH = 2'd2
    } edge_state_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             valid
);
    logic [WIDTH-1:0]  pipe [STAGES];
    logic [STAGES-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
            fill <= '0;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            fill <= {fill[STAGES-2:0], 1'b1};
        end
    end

    assign dout  = pipe[STAGES-1];
    assign valid = fill[STAGES-1];
endmodule

// File: rtl/dio_edge_fsm.sv
module dio_edge_fsm
    import dio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic level_valid,
    input  logic falling_sel,
    output logic edge_hit
);
    edge_state_t state, state_nxt;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ED_WAIT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ED_WAIT: if (level_valid) state_nxt = level ? ED_HIGH : ED_LOW;
            ED_LOW:  if (level)       state_nxt = ED_HIGH;
            ED_HIGH: if (!level)      state_nxt = ED_LOW;
            default:                  state_nxt = ED_WAIT;
        endcase
    end

    always_comb begin
        rise     = (state == ED_LOW)  &&  level;
        fall     = (state == ED_HIGH) && !level;
        edge_hit = falling_sel ? fall : rise;
    end
endmodule

// File: rtl/dio_irq_bank.sv
module dio_irq_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic         stat_wr,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] set_pulse,
    output logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] clr_bits;

    assign clr_bits = stat_wr ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask   <= '0;
            status <= '0;
        end else begin
            if (mask_wr) mask <= wbits;
            status <= (status & ~clr_bits) | set_pulse;
        end
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/dio_grouped_port.sv
module dio_grouped_port
    import dio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);
    localparam int SPARE_BIT = DIR_LSB - 1;

    reg_sel_t                 sel_e;
    logic [PIN_COUNT-1:0]     out_data;
    logic                     hi_inv;
    logic [GROUP_COUNT-1:0]   grp_out;
    logic [EDGE_PINS-1:0]     edge_fall;
    logic [PIN_COUNT-1:0]     sync_lvl;
    logic                     sync_ok;
    logic [PIN_COUNT-1:0]     pin_level;
    logic [EDGE_PINS-1:0]     edge_hit;
    logic [EDGE_PINS-1:0]     irq_mask;
    logic [EDGE_PINS-1:0]     irq_status;
    logic                     ctrl_wr, mask_wr, wr_status;
    logic                     unused_spare;

    assign sel_e        = reg_sel_t'(reg_sel);
    assign ctrl_wr      = reg_wr && (sel_e == SEL_CTRL);
    assign mask_wr      = reg_wr && (sel_e == SEL_MASK);
    assign wr_status    = reg_wr && (sel_e == SEL_STATUS);
    assign unused_spare = reg_wdata[SPARE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            hi_inv    <= 1'b0;
            grp_out   <= '0;
            edge_fall <= '0;
        end else if (ctrl_wr) begin
            out_data  <= reg_wdata[PIN_COUNT-1:0];
            hi_inv    <= reg_wdata[POL_BIT];
            grp_out   <= reg_wdata[DIR_LSB +: GROUP_COUNT];
            edge_fall <= reg_wdata[EDGE_SEL_LSB +: EDGE_PINS];
        end
    end

    dio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_lvl),
        .valid (sync_ok)
    );

    for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_bank
        logic [GROUP_SIZE-1:0] inv_vec;
        if (g == POL_GROUP) begin : g_pol
            assign inv_vec = {GROUP_SIZE{hi_inv}};
        end else begin : g_plain
            assign inv_vec = '0;
        end
        assign pin_oe[g*GROUP_SIZE +: GROUP_SIZE]  = {GROUP_SIZE{grp_out[g]}};
        assign pin_out[g*GROUP_SIZE +: GROUP_SIZE] =
            out_data[g*GROUP_SIZE +: GROUP_SIZE] ^ inv_vec;
        assign pin_level[g*GROUP_SIZE +: GROUP_SIZE] = grp_out[g]
            ? out_data[g*GROUP_SIZE +: GROUP_SIZE]
            : (sync_lvl[g*GROUP_SIZE +: GROUP_SIZE] ^ inv_vec);
    end

    for (genvar i = 0; i < EDGE_PINS; i++) begin : g_edge
        dio_edge_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .level       (sync_lvl[i]),
            .level_valid (sync_ok),
            .falling_sel (edge_fall[i]),
            .edge_hit    (edge_hit[i])
        );
    end

    dio_irq_bank #(.N(EDGE_PINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (mask_wr),
        .stat_wr   (wr_status),
        .wbits     (reg_wdata[IRQ_LSB +: EDGE_PINS]),
        .set_pulse (edge_hit),
        .mask      (irq_mask),
        .status    (irq_status),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel_e)
            SEL_CTRL: begin
                reg_rdata[PIN_COUNT-1:0]                = pin_level;
                reg_rdata[POL_BIT]                      = hi_inv;
                reg_rdata[DIR_LSB +: GROUP_COUNT]       = grp_out;
                reg_rdata[EDGE_SEL_LSB +: EDGE_PINS]    = edge_fall;
            end
            SEL_MASK:   reg_rdata[IRQ_LSB +: EDGE_PINS] = irq_mask;
            SEL_STATUS: reg_rdata[IRQ_LSB +: EDGE_PINS] = irq_status;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dio_port_checker.sv
module dio_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_status,
    input logic [3:0] wbits,
    input logic [3:0] edge_hit,
    input logic [3:0] status,
    input logic [7:0] pin_oe
);
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status & $past(wbits & ~edge_hit)) == 4'h0)); // R7

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status && edge_hit == 4'h0) |=> $stable(status)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != 4'h0) |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R8

    AST_BANK_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe[3:0] == 4'h0) || (pin_oe[3:0] == 4'hF)) &&
        ((pin_oe[7:4] == 4'h0) || (pin_oe[7:4] == 4'hF))); // R2
endmodule

bind dio_grouped_port dio_port_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_status (wr_status),
    .wbits     (reg_wdata[11:8]),
    .edge_hit  (edge_hit),
    .status    (irq_status),
    .pin_oe    (pin_oe)
);

// File: tb/tb_dio_grouped_port.sv
`timescale 1ns/1ps
module tb_dio_grouped_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [7:0]  pin_in = 8'h00;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dio_grouped_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'h0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [15:0] data);
        @(negedge clk);
        reg_sel = sel;
        #0.5;
        data = reg_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        read_reg(2'd0, v); check("R1 ctrl", v, 16'h0000);
        read_reg(2'd1, v); check("R1 mask", v, 16'h0000);
        read_reg(2'd2, v); check("R1 status", v, 16'h0000);
        check("R1 oe", {8'h0, pin_oe}, 16'h0000);
        check("R1 out", {8'h0, pin_out}, 16'h0000);
        check("R1 irq", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_direction();
        write_reg(2'd0, 16'h04A5);
        check("R2 oe low bank", {8'h0, pin_oe}, 16'h000F);
        check("R2 out data", {8'h0, pin_out}, 16'h00A5);
        write_reg(2'd0, 16'h083C);
        check("R2 oe high bank", {8'h0, pin_oe}, 16'h00F0);
        check("R2 out data 2", {8'h0, pin_out}, 16'h003C);
    endtask

    task automatic t_readback();
        logic [15:0] v;
        set_pins(8'h96);
        write_reg(2'd0, 16'h045A);
        settle();
        read_reg(2'd0, v); check("R3 mixed readback", v, 16'h049A);
        set_pins(8'h16);
        @(posedge clk);
        read_reg(2'd0, v); check("R3 one edge old level", v, 16'h049A);
        @(posedge clk);
        read_reg(2'd0, v); check("R3 two edges new level", v, 16'h041A);
    endtask

    task automatic t_polarity();
        logic [15:0] v;
        set_pins(8'h90);
        write_reg(2'd0, 16'h09C3);
        settle();
        check("R4 inverted drive", {8'h0, pin_out}, 16'h0033);
        read_reg(2'd0, v); check("R4 output bank reads data", v, 16'h09C0);
        write_reg(2'd0, 16'h0100);
        settle();
        check("R4 inverted drive input bank", {8'h0, pin_out}, 16'h00F0);
        read_reg(2'd0, v); check("R4 inverted input read", v, 16'h0160);
    endtask

    task automatic t_edge_rise();
        logic [15:0] v;
        set_pins(8'h00);
        write_reg(2'd0, 16'h0000);
        settle();
        write_reg(2'd2, 16'h0F00);
        set_pins(8'h04);
        repeat (2) @(posedge clk);
        read_reg(2'd2, v); check("R5 not yet after two edges", v, 16'h0000);
        @(posedge clk);
        read_reg(2'd2, v); check("R5 rise sets bit10", v, 16'h0400);
        write_reg(2'd2, 16'h0400);
        set_pins(8'h00);
        settle();
        read_reg(2'd2, v); check("R5 fall ignored when rise selected", v, 16'h0000);
    endtask

    task automatic t_edge_fall();
        logic [15:0] v;
        write_reg(2'd0, 16'h2000);
        write_reg(2'd2, 16'h0F00);
        set_pins(8'h02);
        settle();
        read_reg(2'd2, v); check("R5 rise ignored when fall selected", v, 16'h0000);
        set_pins(8'h00);
        settle();
        read_reg(2'd2, v); check("R5 fall sets bit9", v, 16'h0200);
    endtask

    task automatic t_irq_mask();
        logic [15:0] v;
        check("R6 masked status no irq", {15'h0, irq}, 16'h0000);
        write_reg(2'd1, 16'h0200);
        check("R6 irq after unmask", {15'h0, irq}, 16'h0001);
        read_reg(2'd1, v); check("R6 mask readback", v, 16'h0200);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        set_pins(8'h04);
        settle();
        read_reg(2'd2, v); check("R7 two bits set", v, 16'h0600);
        write_reg(2'd2, 16'h0200);
        read_reg(2'd2, v); check("R7 one cleared other kept", v, 16'h0400);
        check("R6 irq drops with masked bit clear", {15'h0, irq}, 16'h0000);
        write_reg(2'd2, 16'h0400);
        set_pins(8'h00);
        settle();
    endtask

    task automatic t_collision();
        logic [15:0] v;
        write_reg(2'd0, 16'h0000);
        write_reg(2'd2, 16'h0F00);
        set_pins(8'h08);
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h0800;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'h0;
        read_reg(2'd2, v); check("R8 set wins over clear", v, 16'h0800);
        write_reg(2'd2, 16'h0800);
        read_reg(2'd2, v); check("R7 later clear works", v, 16'h0000);
        set_pins(8'h00);
        settle();
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        write_reg(2'd1, 16'hFFFF);
        read_reg(2'd1, v); check("R10 mask reserved bits", v, 16'h0F00);
        write_reg(2'd1, 16'h0000);
        set_pins(8'h05);
        settle();
        write_reg(2'd2, 16'h0F00);
        write_reg(2'd0, 16'h0200);
        settle();
        read_reg(2'd0, v); check("R10 ctrl bit9 reads zero", v, 16'h0005);
        write_reg(2'd3, 16'hFFFF);
        read_reg(2'd3, v); check("R10 sel3 reads zero", v, 16'h0000);
        read_reg(2'd0, v); check("R10 sel3 write ignored", v, 16'h0005);
        set_pins(8'hF5);
        settle();
        set_pins(8'h05);
        settle();
        read_reg(2'd2, v); check("R10 high pins no status", v, 16'h0000);
    endtask

    task automatic t_reset_high();
        logic [15:0] v;
        set_pins(8'h01);
        do_reset();
        repeat (8) @(posedge clk);
        read_reg(2'd2, v); check("R9 no spurious edge", v, 16'h0000);
        set_pins(8'h00);
        settle();
        set_pins(8'h01);
        settle();
        read_reg(2'd2, v); check("R9 baseline then rise", v, 16'h0100);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_readback();
        t_polarity();
        t_edge_rise();
        t_edge_fall();
        t_irq_mask();
        t_w1c();
        t_collision();
        t_reserved();
        t_reset_high();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule